// File: doc/BRIEF.md
# Chip-Select Bus Termination Controller

This block sits beside the external bus interface of a 16-bit microcontroller. It produces the chip-select strobes and the acknowledge handshake that ends each external bus cycle. Each chip select has a base address, a block size and a 4-bit acknowledge code. The code selects one of three kinds of ending: an internal acknowledge after a programmed number of wait states, fast termination, or the external acknowledge alone. The two external acknowledge lines are always obeyed, whatever the code says. A cycle-done pulse marks the end of each bus cycle. The block also recognises CPU-space cycles and reports their type.

A cycle is framed by the address strobe. Edge 0 is the first rising clock edge that samples the address strobe high. Later edges are numbered from there. Every output is registered. This block has no streaming data path: termination is the bus's own handshake. The external acknowledge lines and the bus strobes are plain level signals, so there is no valid/ready back-pressure at its edge.

Top module: `cs_term_ctrl`

## Requirements
- R1: A chip-select output goes high after edge 0 when the cycle is not in CPU space (function code 7), its address falls in that chip select's range, and its strobe condition holds. It stays high while the address strobe is high.
- R2: An address is in range when it equals the base address in every bit at or above position `blk`, where `blk` is the log2 of the block size in bytes. When several chip selects match, the lowest index supplies the acknowledge code, the port width and the fast setting.
- R3: Ack codes 0 to 13 give that many wait states. With code N, the internal acknowledge and cycle_done both appear after edge N+1.
- R4: Ack code 4'b1110 (fast termination) raises the internal acknowledge and cycle_done after edge 0. This is one clock earlier than a zero-wait-state cycle.
- R5: Ack code 4'b1111 never raises the internal acknowledge. Only an external acknowledge ends such a cycle.
- R6: Either external acknowledge line ends the cycle at any edge from edge 1 onward, whatever the code. An external acknowledge held from the start therefore gives done after edge 1. An address that matches no chip select also ends this way.
- R7: cycle_done is a single-clock pulse, at most once for each address-strobe assertion.
- R8: The internal acknowledge is 2'b11 for a 16-bit port (port bit 1) and 2'b10 for an 8-bit port (port bit 0). It holds that value until the address strobe drops.
- R9: ds_en is high while the address strobe is high. The exception is a write (rw=0) to a fast-termination chip select: there ds_en stays low.
- R10: A strobe-select bit of 1 qualifies the chip select with the address strobe only. A bit of 0 also requires the data strobe, so a fast write to such a chip select never asserts it.
- R11: One edge after the address strobe is sampled low, every chip select and the internal acknowledge are low, and the wait count restarts for the next cycle.
- R12: In CPU space, cpu_type is set after edge 0 from address bits 19:16. The codes are: 0 → 1 (breakpoint), 3 → 2 (stop broadcast), F → 3 (interrupt acknowledge), any other → 4. Outside CPU space cpu_type is 0, and no chip select asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_fc | input | 3 | Function code (address space) |
| bus_as | input | 1 | Address strobe, active high |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| ext_ack | input | 2 | External acknowledge lines, active high |
| cfg_base | input | NUM_CS*ADDR_W | Base address per chip select |
| cfg_blk | input | NUM_CS*BLK_W | log2 block size per chip select |
| cfg_ack | input | NUM_CS*4 | Acknowledge code per chip select |
| cfg_port16 | input | NUM_CS | 1 = 16-bit port |
| cfg_strb_as | input | NUM_CS | 1 = qualify with address strobe only |
| cs | output | NUM_CS | Chip-select strobes, active high |
| int_ack | output | 2 | Internal acknowledge lines |
| cycle_done | output | 1 | One-clock end-of-cycle pulse |
| ds_en | output | 1 | Data-strobe drive enable |
| cpu_type | output | 3 | CPU-space cycle type |

## Verification
The bench targets the edge on which a cycle ends. It covers each end of the wait-state range, fast termination against zero wait states, and an external acknowledge that arrives before or together with the internal count. An off-by-one counter would show done one edge late or early. A design that ignores the external lines would hang code-15 cycles. The bench also checks that a fast write suppresses the data strobe and so blocks a data-strobe-qualified select. It checks that an 8-bit port acknowledges on one line only, and that CPU-space cycles are typed and never select. A design that leaked a select into CPU space, or drove both lines for a byte port, would fail those checks.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam logic [3:0] ACK_FAST = 4'hE;
  localparam logic [3:0] ACK_EXT  = 4'hF;

  typedef enum logic [2:0] {
    CT_NONE  = 3'd0,
    CT_BKPT  = 3'd1,
    CT_STOP  = 3'd2,
    CT_IACK  = 3'd3,
    CT_OTHER = 3'd4
  } cpu_type_e;

  function automatic cpu_type_e decode_type(input logic [3:0] nib);
    case (nib)
      4'h0:    return CT_BKPT;
      4'h3:    return CT_STOP;
      4'hF:    return CT_IACK;
      default: return CT_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/cst_match.sv
module cst_match #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [BLK_W-1:0]  blk,
  output logic              in_rng
);
  logic [ADDR_W-1:0] diff;
  always_comb begin
    diff   = (addr ^ base) >> blk;
    in_rng = (diff == '0);
  end
endmodule

// File: rtl/cst_wait_timer.sv
module cst_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cst_cpu_decode.sv
module cst_cpu_decode
  import cst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic              cpu_sp,
  input  logic [ADDR_W-1:0] addr,
  output cpu_type_e         ctype
);
  localparam int TOP = ADDR_W - 1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctype <= CT_NONE;
    else if (as_i && cpu_sp)   ctype <= decode_type(addr[TOP -: 4]);
    else                       ctype <= CT_NONE;
  end
endmodule

// File: rtl/cs_term_ctrl.sv
module cs_term_ctrl
  import cst_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 20,
  parameter int BLK_W  = $clog2(ADDR_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [2:0]               bus_fc,
  input  logic                     bus_as,
  input  logic                     bus_ds,
  input  logic                     bus_rw,
  input  logic [1:0]               ext_ack,
  input  logic [NUM_CS*ADDR_W-1:0] cfg_base,
  input  logic [NUM_CS*BLK_W-1:0]  cfg_blk,
  input  logic [NUM_CS*4-1:0]      cfg_ack,
  input  logic [NUM_CS-1:0]        cfg_port16,
  input  logic [NUM_CS-1:0]        cfg_strb_as,
  output logic [NUM_CS-1:0]        cs,
  output logic [1:0]               int_ack,
  output logic                     cycle_done,
  output logic                     ds_en,
  output logic [2:0]               cpu_type
);
  localparam int CNT_W = 4;

  logic              cpu_sp;
  logic [NUM_CS-1:0] in_rng, match;
  logic              hit, sel_port16;
  logic [3:0]        sel_code;
  logic [CNT_W-1:0]  cnt;
  logic              int_cond, ext_ok, done_cond, sel_fast, fin_q;
  cpu_type_e         ctype;

  assign cpu_sp = (bus_fc == 3'd7);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    cst_match #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_match (
      .addr   (bus_addr),
      .base   (cfg_base[i*ADDR_W +: ADDR_W]),
      .blk    (cfg_blk[i*BLK_W +: BLK_W]),
      .in_rng (in_rng[i])
    );
    assign match[i] = bus_as && !cpu_sp && in_rng[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs[i] <= 1'b0;
      else        cs[i] <= match[i] && (cfg_strb_as[i] || bus_ds);
    end
  end

  // lowest matching index wins
  always_comb begin
    sel_code   = ACK_EXT;
    sel_port16 = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_code   = cfg_ack[i*4 +: 4];
        sel_port16 = cfg_port16[i];
      end
    end
  end

  assign hit      = |match;
  assign sel_fast = hit && (sel_code == ACK_FAST);

  cst_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (bus_as),
    .cnt   (cnt)
  );

  always_comb begin
    if (!hit || sel_code == ACK_EXT) int_cond = 1'b0;
    else if (sel_code == ACK_FAST)   int_cond = 1'b1;
    else int_cond = ({1'b0, cnt} >= ({1'b0, sel_code} + 5'd1));
  end

  assign ext_ok    = (|ext_ack) && (cnt != '0);
  assign done_cond = bus_as && !fin_q && (ext_ok || int_cond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_ack    <= 2'b00;
      cycle_done <= 1'b0;
      fin_q      <= 1'b0;
      ds_en      <= 1'b0;
    end else begin
      int_ack    <= int_cond ? (sel_port16 ? 2'b11 : 2'b10) : 2'b00;
      cycle_done <= done_cond;
      fin_q      <= bus_as && (fin_q || done_cond);
      ds_en      <= bus_as && !(sel_fast && !bus_rw);
    end
  end

  cst_cpu_decode #(.ADDR_W(ADDR_W)) u_cpu (
    .clk    (clk),
    .rst_n  (rst_n),
    .as_i   (bus_as),
    .cpu_sp (cpu_sp),
    .addr   (bus_addr),
    .ctype  (ctype)
  );
  assign cpu_type = ctype;
endmodule

// File: rtl/cs_term_ctrl_chk.sv
module cs_term_ctrl_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_as,
  input logic [2:0]        bus_fc,
  input logic [NUM_CS-1:0] cs,
  input logic [1:0]        int_ack,
  input logic              cycle_done,
  input logic              ds_en
);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as |=> (cs == '0 && int_ack == 2'b00 && !ds_en));

  a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);

  a_r12_cpu_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_fc == 3'd7) |=> (cs == '0));

  a_r8_ack_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack != 2'b01);

  a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack != 2'b00 && bus_as) |=> (int_ack == $past(int_ack)));
endmodule

bind cs_term_ctrl cs_term_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_as     (bus_as),
  .bus_fc     (bus_fc),
  .cs         (cs),
  .int_ack    (int_ack),
  .cycle_done (cycle_done),
  .ds_en      (ds_en)
);

// File: tb/cs_term_ctrl_tb.sv
module cs_term_ctrl_tb;
  localparam int NUM_CS = 2;
  localparam int ADDR_W = 20;
  localparam int BLK_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0] bus_fc = 3'd5;
  logic bus_as = 0, bus_ds = 0, bus_rw = 1;
  logic [1:0] ext_ack = 2'b00;
  logic [NUM_CS*ADDR_W-1:0] cfg_base;
  logic [NUM_CS*BLK_W-1:0]  cfg_blk;
  logic [NUM_CS*4-1:0]      cfg_ack;
  logic [NUM_CS-1:0]        cfg_port16, cfg_strb_as;
  logic [NUM_CS-1:0] cs;
  logic [1:0] int_ack;
  logic cycle_done, ds_en;
  logic [2:0] cpu_type;

  int errors = 0, checks = 0;
  int done_at, ack_at, ndone, cs0, ds0, typ0, rel_cs, rel_ack;

  always #5 clk = ~clk;

  cs_term_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_dut (.*);

  // {code[3:0], ext_at[4:0], exp_done[4:0], exp_ack[1:0]}; ext_at 31 = never
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {4'd0,  5'd31, 5'd1,  2'b11},
    {4'd3,  5'd31, 5'd4,  2'b11},
    {4'd13, 5'd31, 5'd14, 2'b11},
    {4'd14, 5'd31, 5'd0,  2'b11},
    {4'd15, 5'd3,  5'd3,  2'b00},
    {4'd15, 5'd0,  5'd1,  2'b00},
    {4'd6,  5'd2,  5'd2,  2'b00},
    {4'd14, 5'd0,  5'd0,  2'b11},
    {4'd2,  5'd3,  5'd3,  2'b11}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [ADDR_W-1:0] a, input logic [2:0] f,
                           input logic rw, input logic ds, input int ext_at);
    done_at = -1; ack_at = 0; ndone = 0;
    @(negedge clk);
    bus_addr = a; bus_fc = f; bus_rw = rw; bus_ds = ds; bus_as = 1'b1;
    for (int k = 0; k < 20; k++) begin
      ext_ack = (k >= ext_at) ? 2'b11 : 2'b00;
      @(negedge clk);
      if (k == 0) begin cs0 = int'(cs); ds0 = int'(ds_en); typ0 = int'(cpu_type); end
      if (cycle_done) begin
        ndone++;
        if (done_at < 0) begin done_at = k; ack_at = int'(int_ack); end
      end
    end
    bus_as = 1'b0; bus_ds = 1'b0; ext_ack = 2'b00;
    @(negedge clk);
    rel_cs = int'(cs); rel_ack = int'(int_ack);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // CS0: 0x10000, 64K, 16-bit, AS-qualified; CS1: 0x20000, 4K, 8-bit, DS-qualified
    cfg_base    = {20'h20000, 20'h10000};
    cfg_blk     = {5'd12, 5'd16};
    cfg_ack     = {4'd0, 4'd0};
    cfg_port16  = 2'b01;
    cfg_strb_as = 2'b01;
    repeat (3) @(negedge clk);
    check("R11 reset cs", int'(cs), 0);
    check("R8 reset int_ack", int'(int_ack), 0);
    check("R7 reset done", int'(cycle_done), 0);
    check("R12 reset cpu_type", int'(cpu_type), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      cfg_ack[3:0] = VEC[v][15:12];
      run_cycle(20'h1_2345, 3'd5, 1'b1, 1'b1, int'(VEC[v][11:7]));
      check($sformatf("R3 R4 R5 R6 done edge v%0d", v), done_at, int'(VEC[v][6:2]));
      check($sformatf("R8 ack at done v%0d", v), ack_at, int'(VEC[v][1:0]));
      check($sformatf("R7 one done v%0d", v), ndone, 1);
      check($sformatf("R1 cs0 v%0d", v), cs0, 1);
      check($sformatf("R11 release v%0d", v), rel_cs + rel_ack, 0);
    end

    // R5: ext-only with no external ack never ends
    cfg_ack[3:0] = 4'hF;
    run_cycle(20'h1_0000, 3'd5, 1'b1, 1'b1, 31);
    check("R5 no done without ext", ndone, 0);

    // R8/R10: CS1 8-bit port, DS-qualified
    run_cycle(20'h2_0010, 3'd5, 1'b1, 1'b1, 31);
    check("R8 byte port ack", ack_at, 2);
    check("R10 cs1 with ds", cs0, 2);
    run_cycle(20'h2_0010, 3'd5, 1'b1, 1'b0, 31);
    check("R10 cs1 without ds", cs0, 0);

    // R2: out of CS1's 4K block (bit 12 differs) -> no select, ext ends it
    run_cycle(20'h2_1010, 3'd5, 1'b1, 1'b1, 0);
    check("R2 out of range cs", cs0, 0);
    check("R6 unmatched ends by ext", done_at, 1);
    check("R2 no int ack", ack_at, 0);

    // R9: fast write vs fast read on CS0
    cfg_ack[3:0] = 4'hE;
    run_cycle(20'h1_0100, 3'd5, 1'b0, 1'b0, 31);
    check("R9 fast write ds_en", ds0, 0);
    run_cycle(20'h1_0100, 3'd5, 1'b1, 1'b1, 31);
    check("R9 fast read ds_en", ds0, 1);
    // R10: fast write to DS-qualified CS1 never selects
    cfg_ack[7:4] = 4'hE;
    run_cycle(20'h2_0000, 3'd5, 1'b0, 1'b0, 31);
    check("R10 fast write ds-qualified cs", cs0, 0);

    // R12: CPU-space types; addresses also inside CS0 range must not select
    run_cycle(20'hF_0000, 3'd7, 1'b1, 1'b1, 0);
    check("R12 iack type", typ0, 3);
    check("R12 cpu no cs", cs0, 0);
    run_cycle(20'h3_0000, 3'd7, 1'b1, 1'b1, 0);
    check("R12 stop type", typ0, 2);
    run_cycle(20'h0_0000, 3'd7, 1'b1, 1'b1, 0);
    check("R12 bkpt type", typ0, 1);
    run_cycle(20'h1_0000, 3'd7, 1'b1, 1'b1, 0);
    check("R12 other type", typ0, 4);
    check("R1 cpu space in range no cs", cs0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule